// File: doc/BRIEF.md
# Register Port Address Selector

This block sits in the decode step of a single-cycle processor. From the 4-bit instruction code, the two 4-bit register fields of the instruction and the outcome of the condition test, it works out which register numbers go to the two read ports of the register file. It also works out which register numbers go to the two write ports. One write port takes the arithmetic result and the other takes the value loaded from memory.

The design has no enable lines. Register number 15 means "no register": a read port addressed with 15 yields a value nobody uses, and a write port addressed with 15 writes nothing. Stack instructions use register 4, the stack pointer, as an implicit operand. The pop instruction uses both write ports in the same cycle.

The block is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `regport_selector`

## Requirements
- R1: For codes 0 (halt), 1 (no-op), 3 (load immediate) and 7 (jump), both read addresses are 15. For codes 0, 1 and 7, both write addresses are also 15.
- R2: For code 2 (register move, conditional or not), `src_a` is the first field and `src_b` is 15. `dst_e` is the second field when `cond_ok` is 1, and 15 when `cond_ok` is 0. `dst_m` is 15.
- R3: For code 3 (load immediate), `dst_e` is the second field and `dst_m` is 15.
- R4: For code 4 (store) and code 6 (arithmetic), `src_a` is the first field and `src_b` is the second field. A store writes nothing (both write addresses 15). An arithmetic instruction sets `dst_e` to the second field and `dst_m` to 15.
- R5: For code 5 (load from memory), `src_a` is 15, `src_b` is the second field, `dst_m` is the first field and `dst_e` is 15.
- R6: For code 8 (call) and code 9 (return), `src_a` is 15, `src_b` is 4, `dst_e` is 4 and `dst_m` is 15.
- R7: For code 10 (push), `src_a` is the first field, `src_b` is 4, `dst_e` is 4 and `dst_m` is 15.
- R8: For code 11 (pop), both read addresses are 4, `dst_e` is 4 and `dst_m` is the first field. Both writes happen in the same cycle.
- R9: Codes 12 to 15 are undefined, and all four outputs are 15 for them.
- R10: `cond_ok` has no effect on any output unless the code is 2.
- R11: A register field is passed through unchanged wherever it is selected. This includes the value 15, which then suppresses that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| icode | input | 4 | Instruction code |
| ra | input | 4 | First register field of the instruction |
| rb | input | 4 | Second register field of the instruction |
| cond_ok | input | 1 | Condition test result for the conditional move |
| src_a | output | 4 | Read port A register number (15 = none) |
| src_b | output | 4 | Read port B register number (15 = none) |
| dst_e | output | 4 | Write address for the arithmetic result (15 = no write) |
| dst_m | output | 4 | Write address for the memory result (15 = no write) |

## Verification
The bench sweeps every combination of instruction code, both register fields and the condition bit. This shows that each instruction class routes the right field to the right port, including field value 4 (the stack pointer) and field value 15. The sweep is followed by seeded random vectors and by directed pairs that differ only in `cond_ok`. Those pairs separate the conditional move, whose write depends on the condition, from every other class, where the condition must not matter. Directed cases on pop with the first field equal to 4, and on the undefined codes, check the dual-write case and the all-suppressed fallback.

// File: rtl/regsel_pkg.sv
package regsel_pkg;
  localparam int OP_W  = 4;
  localparam int REG_W = 4;

  localparam logic [REG_W-1:0] REG_NONE  = '1;
  localparam logic [REG_W-1:0] REG_STACK = REG_W'(4);

  // Class indices equal the instruction codes they decode; CL_BAD covers the rest.
  localparam int CL_HALT  = 0;
  localparam int CL_NOP   = 1;
  localparam int CL_MOVE  = 2;
  localparam int CL_IMM   = 3;
  localparam int CL_STORE = 4;
  localparam int CL_LOAD  = 5;
  localparam int CL_ARITH = 6;
  localparam int CL_JUMP  = 7;
  localparam int CL_CALL  = 8;
  localparam int CL_RET   = 9;
  localparam int CL_PUSH  = 10;
  localparam int CL_POP   = 11;
  localparam int CL_BAD   = 12;
  localparam int NUM_CL   = 13;
  localparam int NUM_DEF  = NUM_CL - 1;

  typedef logic [NUM_CL-1:0] cls_vec_t;

  function automatic logic [OP_W-1:0] cls_code(input int k);
    return OP_W'(k);
  endfunction
endpackage

// File: rtl/regsel_class_dec.sv
module regsel_class_dec
  import regsel_pkg::*;
(
  input  logic [OP_W-1:0] icode,
  output cls_vec_t        cls
);
  logic [NUM_DEF-1:0] hit;

  for (genvar k = 0; k < NUM_DEF; k++) begin : g_hit
    assign hit[k] = (icode == cls_code(k));
  end

  assign cls = {~|hit, hit};
endmodule

// File: rtl/regsel_src_mux.sv
module regsel_src_mux
  import regsel_pkg::*;
(
  input  cls_vec_t         cls,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b
);
  logic use_ra_a, use_sp_a, use_rb_b, use_sp_b;

  always_comb begin
    use_ra_a = cls[CL_MOVE] | cls[CL_STORE] | cls[CL_ARITH] | cls[CL_PUSH];
    use_sp_a = cls[CL_POP];
    use_rb_b = cls[CL_STORE] | cls[CL_LOAD] | cls[CL_ARITH];
    use_sp_b = cls[CL_CALL] | cls[CL_RET] | cls[CL_PUSH] | cls[CL_POP];
  end

  always_comb begin
    src_a = REG_NONE;
    if (use_ra_a)      src_a = ra;
    else if (use_sp_a) src_a = REG_STACK;
  end

  always_comb begin
    src_b = REG_NONE;
    if (use_rb_b)      src_b = rb;
    else if (use_sp_b) src_b = REG_STACK;
  end
endmodule

// File: rtl/regsel_dst_mux.sv
module regsel_dst_mux
  import regsel_pkg::*;
(
  input  cls_vec_t         cls,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic             cond_ok,
  output logic [REG_W-1:0] dst_e,
  output logic [REG_W-1:0] dst_m
);
  logic e_rb, e_sp, m_ra;

  always_comb begin
    e_rb = (cls[CL_MOVE] & cond_ok) | cls[CL_IMM] | cls[CL_ARITH];
    e_sp = cls[CL_CALL] | cls[CL_RET] | cls[CL_PUSH] | cls[CL_POP];
    m_ra = cls[CL_LOAD] | cls[CL_POP];
  end

  always_comb begin
    dst_e = REG_NONE;
    if (e_rb)      dst_e = rb;
    else if (e_sp) dst_e = REG_STACK;
  end

  always_comb begin
    dst_m = REG_NONE;
    if (m_ra) dst_m = ra;
  end
endmodule

// File: rtl/regport_selector.sv
module regport_selector
  import regsel_pkg::*;
(
  input  logic [OP_W-1:0]  icode,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  input  logic             cond_ok,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst_e,
  output logic [REG_W-1:0] dst_m
);
  cls_vec_t cls;

  regsel_class_dec u_dec (
    .icode (icode),
    .cls   (cls)
  );

  regsel_src_mux u_src (
    .cls   (cls),
    .ra    (ra),
    .rb    (rb),
    .src_a (src_a),
    .src_b (src_b)
  );

  regsel_dst_mux u_dst (
    .cls     (cls),
    .ra      (ra),
    .rb      (rb),
    .cond_ok (cond_ok),
    .dst_e   (dst_e),
    .dst_m   (dst_m)
  );

  always_comb begin
    if (!$isunknown({icode, ra, rb, cond_ok})) begin
      AST_CLASS_ONEHOT: assert ($countones(cls) == 1); // R9
      AST_QUIET_NO_READ: assert (!(cls[CL_HALT] | cls[CL_NOP] | cls[CL_JUMP] | cls[CL_IMM])
                                 || (src_a == REG_NONE && src_b == REG_NONE)); // R1
      AST_STACK_ON_B: assert (!(cls[CL_CALL] | cls[CL_RET] | cls[CL_PUSH] | cls[CL_POP])
                              || src_b == REG_STACK); // R6
      AST_POP_DUAL_WRITE: assert (!cls[CL_POP] || (dst_e == REG_STACK && dst_m == ra)); // R8
      AST_MOVE_FALSE_DROP: assert (!(cls[CL_MOVE] && !cond_ok) || dst_e == REG_NONE); // R2
      AST_BAD_SILENT: assert (!cls[CL_BAD] || (src_a == REG_NONE && src_b == REG_NONE
                              && dst_e == REG_NONE && dst_m == REG_NONE)); // R9
    end
  end
endmodule

// File: tb/test_regport_selector.sv
`timescale 1ns/1ps
module test_regport_selector;
  logic       clk;
  logic [3:0] icode, ra, rb;
  logic       cond_ok;
  logic [3:0] src_a, src_b, dst_e, dst_m;
  int n_chk = 0;
  int n_bad = 0;

  regport_selector i_regport_selector (
    .icode(icode), .ra(ra), .rb(rb), .cond_ok(cond_ok),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected {src_a, src_b, dst_e, dst_m}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [3:0] a,
                                        input logic [3:0] b, input logic c);
    logic [3:0] ea, eb, ee, em;
    ea = 4'hF; eb = 4'hF; ee = 4'hF; em = 4'hF;
    case (op)
      4'h2: begin ea = a; ee = c ? b : 4'hF; end
      4'h3: ee = b;
      4'h4: begin ea = a; eb = b; end
      4'h5: begin eb = b; em = a; end
      4'h6: begin ea = a; eb = b; ee = b; end
      4'h8, 4'h9: begin eb = 4'h4; ee = 4'h4; end
      4'hA: begin ea = a; eb = 4'h4; ee = 4'h4; end
      4'hB: begin ea = 4'h4; eb = 4'h4; ee = 4'h4; em = a; end
      default: ;
    endcase
    return {ea, eb, ee, em};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h7: return "R1";
      4'h2: return "R2";
      4'h3: return "R3";
      4'h4, 4'h6: return "R4";
      4'h5: return "R5";
      4'h8, 4'h9: return "R6";
      4'hA: return "R7";
      4'hB: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic c);
    @(negedge clk);
    icode = op; ra = a; rb = b; cond_ok = c;
    #5;
  endtask

  task automatic check(input string tag, input logic [15:0] exp);
    n_chk++;
    if ({src_a, src_b, dst_e, dst_m} !== exp) begin
      n_bad++;
      $display("FAIL %s icode=%h ra=%h rb=%h c=%b actual=%h expected=%h",
               tag, icode, ra, rb, cond_ok, {src_a, src_b, dst_e, dst_m}, exp);
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] first;
    void'($urandom(32'd20240611));
    // Directed: pop with first field = stack pointer, both writes to 4 (R8)
    apply(4'hB, 4'h4, 4'h7, 1'b0); check("R8", 16'h4444);
    // Directed: conditional move, false then true (R2)
    apply(4'h2, 4'h3, 4'h9, 1'b0); check("R2", 16'h3FFF);
    apply(4'h2, 4'h3, 4'h9, 1'b1); check("R2", 16'h3F9F);
    // Directed: field 15 passes through and suppresses (R11)
    apply(4'hA, 4'hF, 4'h2, 1'b1); check("R11", 16'hF44F);
    apply(4'h6, 4'h1, 4'hF, 1'b0); check("R11", 16'h1FFF);
    // Directed: undefined code (R9)
    apply(4'hD, 4'h2, 4'h3, 1'b1); check("R9", 16'hFFFF);
    // R10: condition bit has no effect outside code 2
    for (int op = 0; op < 16; op++) begin
      if (op != 2) begin
        apply(4'(op), 4'h5, 4'hA, 1'b0);
        first = {src_a, src_b, dst_e, dst_m};
        apply(4'(op), 4'h5, 4'hA, 1'b1);
        check("R10", first);
      end
    end
    // Exhaustive sweep (R1-class routing per code)
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            apply(4'(op), 4'(a), 4'(b), 1'(c));
            check(tag_of(4'(op)), model(4'(op), 4'(a), 4'(b), 1'(c)));
          end
    // Seeded random vectors
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] op, a, b;
      logic c;
      op = 4'($urandom); a = 4'($urandom); b = 4'($urandom); c = 1'($urandom);
      apply(op, a, b, c);
      check(tag_of(op), model(op, a, b, c));
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule